// File: doc/BRIEF.md
# Calendar Shadow Register Coherent Reader

This block stands between a free-running calendar (subsecond count, time of day, date) and a register read port. It keeps a shadow copy of each of the three calendar values. A single-cycle update strobe refreshes the shadows from the live counters. Software reads the shadows one register per access. A read therefore returns values that all belong to the same calendar instant, even while the counters keep running.

Coherence comes from a freeze on the shadows. A subsecond read freezes the time and date shadows. A time read freezes the date shadow. A date read ends the sequence and lifts every freeze. Updates that arrive while a shadow is frozen are dropped for that shadow; a shadow that was frozen is refreshed again only by the next strobe after the release. A fresh flag tells software that new shadow data has been captured since the last date read. A bypass input sends the live counters straight to the read port and turns the freeze mechanism off.

Top module: `cal_shadow_reader`

## Requirements
- R1: After reset all three shadows read as zero, no freeze is active and `fresh_o` is low.
- R2: When bypass is low, an update strobe with no effective read in the same cycle copies the live subsecond value into its shadow. It also copies the live time and date values into any of their shadows that are not frozen, and sets `fresh_o` on the next cycle.
- R3: An effective read with `sel_i`=0 (subseconds) freezes both the time and date shadows from the next cycle on. Later update strobes leave those two shadows unchanged but still refresh the subsecond shadow.
- R4: An effective read with `sel_i`=1 (time) freezes only the date shadow. Later update strobes still refresh the subsecond and time shadows if the time shadow is not already frozen.
- R5: An effective read with `sel_i`=2 (date) lifts every freeze, including when no other register was read first. A shadow that was frozen is not refreshed on release; it is refreshed at the next update strobe.
- R6: When an effective read and an update strobe come in the same cycle, no shadow changes in that cycle.
- R7: A subsecond read one cycle before an update strobe still keeps the time and date shadows at their earlier values.
- R8: An effective date read clears `fresh_o` on the next cycle.
- R9: While `bypass_i` is high, `rdata_o` shows the live value of the selected register in the same cycle. Reads change no state. Every freeze is lifted, and update strobes refresh all three shadows.
- R10: `sel_i`=3 returns zero, and a read with that select has no effect on any shadow, freeze or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_i | input | 1 | Calendar update strobe, one cycle per update |
| rd_i | input | 1 | Read strobe |
| sel_i | input | 2 | Register select: 0 subseconds, 1 time, 2 date, 3 unused |
| bypass_i | input | 1 | Return live values and disable freezing |
| live_ss_i | input | SS_W | Live subsecond count |
| live_tm_i | input | TM_W | Live time of day |
| live_dt_i | input | DT_W | Live date |
| rdata_o | output | DATA_W | Read data, zero-extended, valid in the cycle of `rd_i` |
| fresh_o | output | 1 | Shadow data refreshed since the last date read |

## Verification
A freeze flag stuck low lets the time or date value from a later update appear on `rdata_o` on the very next read of that register, often within a few cycles. A stuck-high freeze shows up as a stale value after the next date read and update. If the same-cycle collision is handled wrongly, the shadow read right after the colliding cycle returns the new live value instead of the old snapshot. A wrong `fresh_o` is visible one cycle after the strobe or date read that should have changed it. The bench compares every cycle of a long mixed stream of reads, strobes and bypass periods against a model built from the rules above, so any of these faults shows within one read of the cycle where it happens.

// File: rtl/cal_shadow_reader.sv
module cal_shadow_reader #(
  parameter int SS_W = 16,
  parameter int TM_W = 17,
  parameter int DT_W = 16,
  localparam int DATA_W = (SS_W > TM_W) ? ((SS_W > DT_W) ? SS_W : DT_W)
                                        : ((TM_W > DT_W) ? TM_W : DT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_i,
  input  logic              rd_i,
  input  logic [1:0]        sel_i,
  input  logic              bypass_i,
  input  logic [SS_W-1:0]   live_ss_i,
  input  logic [TM_W-1:0]   live_tm_i,
  input  logic [DT_W-1:0]   live_dt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              fresh_o
);
  localparam logic [1:0] SEL_SS = 2'd0;
  localparam logic [1:0] SEL_TM = 2'd1;
  localparam logic [1:0] SEL_DT = 2'd2;

  logic [SS_W-1:0] sh_ss;
  logic [TM_W-1:0] sh_tm;
  logic [DT_W-1:0] sh_dt;
  logic            frz_tm, frz_dt, fresh_q;

  wire rd_eff  = rd_i && !bypass_i && (sel_i != 2'd3);
  wire refresh = upd_i && !rd_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_ss   <= '0;
      sh_tm   <= '0;
      sh_dt   <= '0;
      frz_tm  <= 1'b0;
      frz_dt  <= 1'b0;
      fresh_q <= 1'b0;
    end else begin
      if (refresh) begin
        sh_ss   <= live_ss_i;
        if (bypass_i || !frz_tm) sh_tm <= live_tm_i;
        if (bypass_i || !frz_dt) sh_dt <= live_dt_i;
        fresh_q <= 1'b1;
      end
      if (bypass_i) begin
        frz_tm <= 1'b0;
        frz_dt <= 1'b0;
      end else if (rd_eff) begin
        case (sel_i)
          SEL_SS: begin frz_tm <= 1'b1; frz_dt <= 1'b1; end
          SEL_TM: frz_dt <= 1'b1;
          SEL_DT: begin frz_tm <= 1'b0; frz_dt <= 1'b0; fresh_q <= 1'b0; end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (sel_i)
      SEL_SS: rdata_o = DATA_W'(bypass_i ? live_ss_i : sh_ss);
      SEL_TM: rdata_o = DATA_W'(bypass_i ? live_tm_i : sh_tm);
      SEL_DT: rdata_o = DATA_W'(bypass_i ? live_dt_i : sh_dt);
      default: rdata_o = '0;
    endcase
  end

  assign fresh_o = fresh_q;

  assert_ss_read_freezes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_eff && sel_i == SEL_SS) |=> (frz_tm && frz_dt));

  assert_tm_read_freezes_date_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_eff && sel_i == SEL_TM) |=> frz_dt);

  assert_frozen_time_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_tm && !bypass_i) |=> $stable(sh_tm));

  assert_collision_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_eff && upd_i) |=> ($stable(sh_ss) && $stable(sh_tm) && $stable(sh_dt)));

  assert_date_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_eff && sel_i == SEL_DT) |=> (!fresh_o && !frz_tm && !frz_dt));

  assert_bypass_unlocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_i |=> (!frz_tm && !frz_dt));

  assert_update_sets_fresh_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && !rd_i) |=> fresh_o);
endmodule

// File: tb/tb_cal_shadow_reader.sv
module tb_cal_shadow_reader;
  localparam int SS_W = 16, TM_W = 17, DT_W = 16, DATA_W = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_i = 1'b0, rd_i = 1'b0, bypass_i = 1'b0;
  logic [1:0] sel_i = 2'd0;
  logic [SS_W-1:0] live_ss_i = '0;
  logic [TM_W-1:0] live_tm_i = '0;
  logic [DT_W-1:0] live_dt_i = '0;
  logic [DATA_W-1:0] rdata_o;
  logic fresh_o;

  always #4 clk = ~clk;

  cal_shadow_reader #(.SS_W(SS_W), .TM_W(TM_W), .DT_W(DT_W)) dut (
    .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .rd_i(rd_i), .sel_i(sel_i),
    .bypass_i(bypass_i), .live_ss_i(live_ss_i), .live_tm_i(live_tm_i),
    .live_dt_i(live_dt_i), .rdata_o(rdata_o), .fresh_o(fresh_o));

  int checks = 0, errors = 0, cyc = 0;
  logic [SS_W-1:0] m_ss = '0;
  logic [TM_W-1:0] m_tm = '0;
  logic [DT_W-1:0] m_dt = '0;
  logic m_ftm = 1'b0, m_fdt = 1'b0, m_fresh = 1'b0;

  task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  task automatic step(input logic rd, input logic [1:0] sel, input logic upd,
                      input logic byp, input string tag);
    logic [DATA_W-1:0] exp;
    logic rde;
    @(negedge clk);
    cyc++;
    live_ss_i = SS_W'(cyc * 3 + 1);
    live_tm_i = TM_W'(cyc * 5 + 7);
    live_dt_i = DT_W'(cyc * 11 + 2);
    rd_i = rd; sel_i = sel; upd_i = upd; bypass_i = byp;
    case (sel)
      2'd0: exp = DATA_W'(byp ? live_ss_i : m_ss);
      2'd1: exp = DATA_W'(byp ? live_tm_i : m_tm);
      2'd2: exp = DATA_W'(byp ? live_dt_i : m_dt);
      default: exp = '0;
    endcase
    #1;
    check(tag, rdata_o, exp);
    rde = rd && !byp && sel != 2'd3;
    @(posedge clk);
    if (upd && !rde) begin
      m_ss = live_ss_i;
      if (byp || !m_ftm) m_tm = live_tm_i;
      if (byp || !m_fdt) m_dt = live_dt_i;
      m_fresh = 1'b1;
    end
    if (byp) begin m_ftm = 1'b0; m_fdt = 1'b0; end
    else if (rde) begin
      if (sel == 2'd0) begin m_ftm = 1'b1; m_fdt = 1'b1; end
      else if (sel == 2'd1) m_fdt = 1'b1;
      else begin m_ftm = 1'b0; m_fdt = 1'b0; m_fresh = 1'b0; end
    end
    #1;
    check({tag, "_fresh"}, DATA_W'(fresh_o), DATA_W'(m_fresh));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state, no updates yet
    step(1, 2'd0, 0, 0, "R1");
    step(1, 2'd1, 0, 0, "R1");
    step(1, 2'd2, 0, 0, "R1");
    // R2: plain refresh then read each
    step(0, 2'd0, 1, 0, "R2");
    step(1, 2'd0, 0, 0, "R2");
    step(1, 2'd1, 0, 0, "R2");
    step(1, 2'd2, 0, 0, "R8");
    // R3 then R7: subsecond read, update the next cycle, time/date keep old
    step(0, 2'd0, 1, 0, "R2");
    step(1, 2'd0, 0, 0, "R3");
    step(0, 2'd0, 1, 0, "R7");
    step(1, 2'd0, 0, 0, "R3");
    step(1, 2'd1, 0, 0, "R7");
    step(1, 2'd2, 0, 0, "R7");
    // R5: released shadows stay until next strobe
    step(1, 2'd1, 0, 0, "R5");
    step(0, 2'd0, 1, 0, "R5");
    step(1, 2'd1, 0, 0, "R5");
    // R4: time read freezes date only
    step(0, 2'd0, 1, 0, "R4");
    step(1, 2'd0, 0, 0, "R4");
    step(1, 2'd1, 0, 0, "R4");
    step(1, 2'd2, 0, 0, "R4");
    step(1, 2'd2, 0, 0, "R5");
    // R6: same-cycle read and strobe
    step(1, 2'd0, 1, 0, "R6");
    step(1, 2'd0, 0, 0, "R6");
    step(1, 2'd2, 1, 0, "R6");
    step(1, 2'd2, 0, 0, "R6");
    // R10: unused select
    step(1, 2'd3, 1, 0, "R10");
    step(1, 2'd3, 0, 0, "R10");
    step(1, 2'd0, 0, 0, "R10");
    // R9: bypass
    step(1, 2'd0, 0, 1, "R9");
    step(1, 2'd1, 1, 1, "R9");
    step(1, 2'd2, 0, 1, "R9");
    step(1, 2'd1, 0, 0, "R9");
    step(1, 2'd2, 0, 0, "R9");
    // near-exhaustive mixed stream
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      step(lfsr[0], lfsr[2:1], lfsr[3] | lfsr[4], lfsr[7:5] == 3'd0, "R2");
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule